// File: doc/BRIEF.md
# Strobed Configuration Register Bank

This block sits on the receiving end of a board-level configuration bus. A controller places a byte on a shared 8-bit data bus and asserts an active-low output enable. It then pulses one of three active-low strobes. The block keeps three 8-bit control registers: system control, monitor routing and clock/routing. Each register takes the bus byte when its strobe returns high while the enable is asserted.

Every bus, enable and strobe line passes through a two-stage synchronizer into the system clock domain, and strobe edges are detected there. The registers are available raw and also as decoded fields: codec power, mute, phantom power, input source selections, monitor paths, and a clock section. The clock section reports a sample rate in units of 100 Hz and the external sync mode. It also flags reserved rate codes, illegal external-clock combinations and the unsupported input 1/2 mode.

Top module: `cfg_strobe_regs`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all three registers become 0x00. The decoded outputs then show `codec_run`=0, `phantom_on`=1, `ext_sync`=0 and `rate_x100hz`=441.
- R2: A low-to-high transition of a strobe (`sys_stb_n`, `mon_stb_n` or `clkcfg_stb_n`) while `bus_oe_n` is low loads the bus byte into that strobe's register only. Strobes that rise together load the same byte into each of their registers.
- R3: A strobe rising while `bus_oe_n` is high leaves every register and every decoded output unchanged.
- R4: `mon_reg` bits 7 and 6 always read 0. `mon_paths[k]` equals monitor register bit k for k = 0 to 5, active high.
- R5: System register decode: `mic_relay`=bit0, `phantom_48v`=bit1, `mute_on`=bit2, `phantom_on`=NOT bit3, `in34_hiz`=bit6, `codec_run`=bit7 (bit7 = 0 means codec powered down).
- R6: `in12_mode` equals system register bits 5:4 (00 line, 01 mic, 11 mic with low-cut). `in12_mode_bad` is 1 exactly when these bits are 10.
- R7: With clock register bit3 = 0 (internal sync), bits 2:0 select the rate. Codes 0..5 give `rate_x100hz` values 441, 480, 882, 960, 1764 and 1920 with `rate_bad`=0. Codes 6 and 7 give `rate_x100hz`=0 and `rate_bad`=1. Bit 4 is ignored in this mode.
- R8: With bit3 = 1 (external sync), `rate_x100hz`=0 and `rate_bad`=0. The pattern {bit4, bits2:0} sets the mode: 0000 gives `ext_mode`=0 (S/PDIF), 0010 gives 1 (word clock 1x) and 1010 gives 2 (word clock 256x). Any other pattern gives `ext_mode`=3 and `ext_bad`=1. With internal sync, `ext_mode`=3 and `ext_bad`=0.
- R9: `coax_i2s`, `in12_from34` and `in34_digital` equal clock register bits 5, 6 and 7.
- R10: When a strobe input goes high between clock edges, the new value is not yet visible after the second rising edge that follows. It is visible after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_data | input | 8 | Shared configuration data bus |
| bus_oe_n | input | 1 | Bus output enable, active low |
| sys_stb_n | input | 1 | System control register strobe, active low |
| mon_stb_n | input | 1 | Monitor routing register strobe, active low |
| clkcfg_stb_n | input | 1 | Clock/routing register strobe, active low |
| sys_reg | output | 8 | System control register contents |
| mon_reg | output | 8 | Monitor routing register contents |
| clkcfg_reg | output | 8 | Clock/routing register contents |
| codec_run | output | 1 | Codec out of power-down |
| mute_on | output | 1 | Hardware mute engaged |
| phantom_on | output | 1 | Phantom power enabled |
| phantom_48v | output | 1 | Phantom voltage high setting |
| mic_relay | output | 1 | Mic/line relay in mic position |
| in12_mode | output | 2 | Input 1/2 source code |
| in12_mode_bad | output | 1 | Unsupported input 1/2 code |
| in34_hiz | output | 1 | Input 3/4 high-impedance selection |
| mon_paths | output | 6 | Monitor routing path enables |
| ext_sync | output | 1 | External sync source selected |
| rate_x100hz | output | 11 | Internal sample rate in units of 100 Hz, 0 if none |
| rate_bad | output | 1 | Reserved internal rate code |
| ext_mode | output | 2 | External clock mode code |
| ext_bad | output | 1 | Illegal external clock combination |
| coax_i2s | output | 1 | Coax output carries serial audio instead of S/PDIF |
| in12_from34 | output | 1 | Input pair 1/2 taken from analog 3/4 |
| in34_digital | output | 1 | Input pair 3/4 taken from digital input |

## Verification
Two register captures can happen in the same cycle when two or three strobes rise together. Each register has its own edge detector, so each one must take the shared byte independently. The bench provokes this through random strobe masks and a directed write that raises all three strobes at once. It then compares every register and decoded field against its own model, where each selected register holds the byte and each unselected one keeps its old value. A strobe edge that arrives with the enable deasserted falls in the same stream of writes and must leave the model unchanged.

// File: rtl/cfgbus_pkg.sv
// Shared constants and types for the strobed configuration register bank.
package cfgbus_pkg;
    localparam int CFG_W   = 8;   // width of every register and of the bus
    localparam int NREG    = 3;   // number of strobed registers
    localparam int IDX_SYS = 0;   // strobe/register index: system control
    localparam int IDX_MON = 1;   // strobe/register index: monitor routing
    localparam int IDX_CLK = 2;   // strobe/register index: clock/routing
    localparam int RATE_W  = 11;  // width of the rate output (units of 100 Hz)

    typedef enum logic [1:0] {
        EXT_SPDIF  = 2'd0,
        EXT_WC1X   = 2'd1,
        EXT_WC256X = 2'd2,
        EXT_NONE   = 2'd3
    } ext_mode_t;
endpackage

// File: rtl/cfg_sync.sv
// Multi-stage synchronizer for a bus of asynchronous inputs.
// Assumes each bit is sampled independently; the caller keeps the bus
// stable around strobe edges so skew between bits is harmless.
module cfg_sync #(
    parameter int           W         = 8,
    parameter int           STAGES    = 2,
    parameter logic [W-1:0] RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stage_q;

    // Shift the inputs through the stages; reset to the idle level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RESET_VAL;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_capture.sv
// Per-register rising-edge detection and capture.
// Assumes synchronized inputs. A register loads the synchronized bus on
// the cycle its strobe is seen rising with the enable low. KEEP_MASK
// clears the unused bits so that they always read zero.
module cfg_capture #(
    parameter int                 NREG      = 3,
    parameter int                 W         = 8,
    parameter logic [NREG*W-1:0]  KEEP_MASK = '1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [W-1:0]              bus_s,
    input  logic                      oe_s_n,
    input  logic [NREG-1:0]           stb_s_n,
    output logic [NREG-1:0][W-1:0]    regs,
    output logic [NREG-1:0]           cap_pulse
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic         prev_q;
        logic [W-1:0] data_q;
        logic         cap;

        assign cap = stb_s_n[g] & ~prev_q & ~oe_s_n;

        // Remember the last strobe level; idle level is high.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b1;
            else        prev_q <= stb_s_n[g];
        end

        // Load the bus on a qualified rising strobe edge.
        always_ff @(posedge clk) begin
            if (!rst_n)   data_q <= '0;
            else if (cap) data_q <= bus_s & KEEP_MASK[g*W +: W];
        end

        assign regs[g]      = data_q;
        assign cap_pulse[g] = cap;
    end
endmodule

// File: rtl/cfg_clock_decode.sv
// Decodes the low five bits of the clock/routing register into a sample
// rate (units of 100 Hz) or an external sync mode, with error flags.
// Purely combinational.
module cfg_clock_decode
    import cfgbus_pkg::*;
(
    input  logic [4:0]        cfg,
    output logic              ext_sync,
    output logic [RATE_W-1:0] rate_x100hz,
    output logic              rate_bad,
    output ext_mode_t         ext_mode,
    output logic              ext_bad
);
    assign ext_sync = cfg[3];

    // Select rate or external mode and raise flags for reserved codes.
    always_comb begin
        rate_x100hz = '0;
        rate_bad    = 1'b0;
        ext_mode    = EXT_NONE;
        ext_bad     = 1'b0;
        if (!cfg[3]) begin
            case (cfg[2:0])
                3'd0:    rate_x100hz = RATE_W'(441);
                3'd1:    rate_x100hz = RATE_W'(480);
                3'd2:    rate_x100hz = RATE_W'(882);
                3'd3:    rate_x100hz = RATE_W'(960);
                3'd4:    rate_x100hz = RATE_W'(1764);
                3'd5:    rate_x100hz = RATE_W'(1920);
                default: rate_bad    = 1'b1;
            endcase
        end else begin
            case ({cfg[4], cfg[2:0]})
                4'b0000: ext_mode = EXT_SPDIF;
                4'b0010: ext_mode = EXT_WC1X;
                4'b1010: ext_mode = EXT_WC256X;
                default: ext_bad  = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/cfg_strobe_regs.sv
// Top of the strobed configuration register bank.
// Synchronizes bus, enable and strobes, captures three registers and
// exposes their decoded fields. Assumes the writer holds the bus stable
// from before the enable falls until after the strobe rises.
module cfg_strobe_regs
    import cfgbus_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        bus_data,
    input  logic              bus_oe_n,
    input  logic              sys_stb_n,
    input  logic              mon_stb_n,
    input  logic              clkcfg_stb_n,
    output logic [7:0]        sys_reg,
    output logic [7:0]        mon_reg,
    output logic [7:0]        clkcfg_reg,
    output logic              codec_run,
    output logic              mute_on,
    output logic              phantom_on,
    output logic              phantom_48v,
    output logic              mic_relay,
    output logic [1:0]        in12_mode,
    output logic              in12_mode_bad,
    output logic              in34_hiz,
    output logic [5:0]        mon_paths,
    output logic              ext_sync,
    output logic [10:0]       rate_x100hz,
    output logic              rate_bad,
    output logic [1:0]        ext_mode,
    output logic              ext_bad,
    output logic              coax_i2s,
    output logic              in12_from34,
    output logic              in34_digital
);
    localparam int CTRL_W = NREG + 1;
    localparam logic [NREG*CFG_W-1:0] KEEP = {8'hFF, 8'h3F, 8'hFF};

    logic [CFG_W-1:0]             bus_s;
    logic [CTRL_W-1:0]            ctrl_s;
    logic [NREG-1:0][CFG_W-1:0]   regs;
    logic [NREG-1:0]              cap_pulse;
    ext_mode_t                    ext_mode_e;

    cfg_sync #(.W(CFG_W), .STAGES(SYNC_STAGES), .RESET_VAL('0)) u_sync_bus (
        .clk(clk), .rst_n(rst_n), .d(bus_data), .q(bus_s)
    );

    cfg_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .RESET_VAL('1)) u_sync_ctrl (
        .clk(clk), .rst_n(rst_n),
        .d({bus_oe_n, clkcfg_stb_n, mon_stb_n, sys_stb_n}),
        .q(ctrl_s)
    );

    cfg_capture #(.NREG(NREG), .W(CFG_W), .KEEP_MASK(KEEP)) u_capture (
        .clk(clk), .rst_n(rst_n),
        .bus_s(bus_s), .oe_s_n(ctrl_s[NREG]), .stb_s_n(ctrl_s[NREG-1:0]),
        .regs(regs), .cap_pulse(cap_pulse)
    );

    cfg_clock_decode u_clkdec (
        .cfg(regs[IDX_CLK][4:0]),
        .ext_sync(ext_sync), .rate_x100hz(rate_x100hz), .rate_bad(rate_bad),
        .ext_mode(ext_mode_e), .ext_bad(ext_bad)
    );

    assign ext_mode = ext_mode_e;

    assign sys_reg    = regs[IDX_SYS];
    assign mon_reg    = regs[IDX_MON];
    assign clkcfg_reg = regs[IDX_CLK];

    // System control fields.
    assign mic_relay     = sys_reg[0];
    assign phantom_48v   = sys_reg[1];
    assign mute_on       = sys_reg[2];
    assign phantom_on    = ~sys_reg[3];
    assign in12_mode     = sys_reg[5:4];
    assign in12_mode_bad = (sys_reg[5:4] == 2'b10);
    assign in34_hiz      = sys_reg[6];
    assign codec_run     = sys_reg[7];

    // Monitor and routing fields.
    assign mon_paths    = mon_reg[5:0];
    assign coax_i2s     = clkcfg_reg[5];
    assign in12_from34  = clkcfg_reg[6];
    assign in34_digital = clkcfg_reg[7];
endmodule

// File: rtl/cfg_strobe_regs_chk.sv
// Assertion checker for cfg_strobe_regs, attached with bind.
module cfg_strobe_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  bus_s,
    input logic [2:0]  cap_pulse,
    input logic [7:0]  sys_reg,
    input logic [7:0]  mon_reg,
    input logic [7:0]  clkcfg_reg,
    input logic [10:0] rate_x100hz,
    input logic        rate_bad,
    input logic        ext_sync,
    input logic [1:0]  ext_mode,
    input logic        ext_bad
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (sys_reg == 8'h00 && mon_reg == 8'h00 && clkcfg_reg == 8'h00));

    p_load_sys_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pulse[0] |=> sys_reg == $past(bus_s));
    p_load_mon_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pulse[1] |=> mon_reg == ($past(bus_s) & 8'h3F));
    p_load_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pulse[2] |=> clkcfg_reg == $past(bus_s));

    p_hold_sys_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_pulse[0] |=> $stable(sys_reg));
    p_hold_mon_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_pulse[1] |=> $stable(mon_reg));
    p_hold_clk_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_pulse[2] |=> $stable(clkcfg_reg));

    p_mon_top_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mon_reg[7:6] == 2'b00);

    p_rate_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rate_bad |-> (rate_x100hz == 11'd0 && !ext_sync));

    p_ext_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ext_bad |-> (ext_sync && ext_mode == 2'd3 && rate_x100hz == 11'd0));
endmodule

bind cfg_strobe_regs cfg_strobe_regs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_s(bus_s), .cap_pulse(cap_pulse),
    .sys_reg(sys_reg), .mon_reg(mon_reg), .clkcfg_reg(clkcfg_reg),
    .rate_x100hz(rate_x100hz), .rate_bad(rate_bad), .ext_sync(ext_sync),
    .ext_mode(ext_mode), .ext_bad(ext_bad)
);

// File: tb/cfg_strobe_regs_test.sv
module cfg_strobe_regs_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] bus_data = 8'h00;
    logic bus_oe_n = 1'b1, sys_stb_n = 1'b1, mon_stb_n = 1'b1, clkcfg_stb_n = 1'b1;
    logic [7:0] sys_reg, mon_reg, clkcfg_reg;
    logic codec_run, mute_on, phantom_on, phantom_48v, mic_relay;
    logic [1:0] in12_mode;
    logic in12_mode_bad, in34_hiz;
    logic [5:0] mon_paths;
    logic ext_sync;
    logic [10:0] rate_x100hz;
    logic rate_bad;
    logic [1:0] ext_mode;
    logic ext_bad, coax_i2s, in12_from34, in34_digital;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] m_sys = 8'h00, m_mon = 8'h00, m_clk = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_strobe_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_oe_n(bus_oe_n),
        .sys_stb_n(sys_stb_n), .mon_stb_n(mon_stb_n), .clkcfg_stb_n(clkcfg_stb_n),
        .sys_reg(sys_reg), .mon_reg(mon_reg), .clkcfg_reg(clkcfg_reg),
        .codec_run(codec_run), .mute_on(mute_on), .phantom_on(phantom_on),
        .phantom_48v(phantom_48v), .mic_relay(mic_relay), .in12_mode(in12_mode),
        .in12_mode_bad(in12_mode_bad), .in34_hiz(in34_hiz), .mon_paths(mon_paths),
        .ext_sync(ext_sync), .rate_x100hz(rate_x100hz), .rate_bad(rate_bad),
        .ext_mode(ext_mode), .ext_bad(ext_bad), .coax_i2s(coax_i2s),
        .in12_from34(in12_from34), .in34_digital(in34_digital)
    );

    function automatic int exp_rate(input logic [7:0] c);
        if (c[3]) return 0;
        case (c[2:0])
            3'd0: return 441;
            3'd1: return 480;
            3'd2: return 882;
            3'd3: return 960;
            3'd4: return 1764;
            3'd5: return 1920;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_emode(input logic [7:0] c);
        if (!c[3]) return 3;
        if ({c[4], c[2:0]} == 4'b0000) return 0;
        if ({c[4], c[2:0]} == 4'b0010) return 1;
        if ({c[4], c[2:0]} == 4'b1010) return 2;
        return 3;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_all(input string ctx);
        chk({ctx, " R2 sys_reg"}, sys_reg, m_sys);
        chk({ctx, " R2 R4 mon_reg"}, mon_reg, m_mon);
        chk({ctx, " R2 clkcfg_reg"}, clkcfg_reg, m_clk);
        chk({ctx, " R5 relay"}, mic_relay, m_sys[0]);
        chk({ctx, " R5 48v"}, phantom_48v, m_sys[1]);
        chk({ctx, " R5 mute"}, mute_on, m_sys[2]);
        chk({ctx, " R5 phantom"}, phantom_on, !m_sys[3]);
        chk({ctx, " R5 hiz"}, in34_hiz, m_sys[6]);
        chk({ctx, " R5 codec"}, codec_run, m_sys[7]);
        chk({ctx, " R6 mode"}, in12_mode, m_sys[5:4]);
        chk({ctx, " R6 bad"}, in12_mode_bad, m_sys[5:4] == 2'b10);
        chk({ctx, " R4 paths"}, mon_paths, m_mon[5:0]);
        chk({ctx, " R7 rate"}, rate_x100hz, exp_rate(m_clk));
        chk({ctx, " R7 rate_bad"}, rate_bad, !m_clk[3] && m_clk[2:0] >= 3'd6);
        chk({ctx, " R8 ext_sync"}, ext_sync, m_clk[3]);
        chk({ctx, " R8 ext_mode"}, ext_mode, exp_emode(m_clk));
        chk({ctx, " R8 ext_bad"}, ext_bad, m_clk[3] && exp_emode(m_clk) == 3);
        chk({ctx, " R9 coax"}, coax_i2s, m_clk[5]);
        chk({ctx, " R9 in12src"}, in12_from34, m_clk[6]);
        chk({ctx, " R9 in34src"}, in34_digital, m_clk[7]);
    endtask

    // mask bit0 = system, bit1 = monitor, bit2 = clock register
    task automatic bus_write(input logic [2:0] mask, input logic [7:0] val, input bit oe_on);
        @(negedge clk);
        bus_data = val;
        repeat (3) @(negedge clk);
        bus_oe_n = !oe_on;
        repeat (3) @(negedge clk);
        {clkcfg_stb_n, mon_stb_n, sys_stb_n} = ~mask;
        repeat (3) @(negedge clk);
        {clkcfg_stb_n, mon_stb_n, sys_stb_n} = 3'b111;
        repeat (3) @(negedge clk);
        bus_oe_n = 1'b1;
        repeat (4) @(negedge clk);
        if (oe_on) begin
            if (mask[0]) m_sys = val;
            if (mask[1]) m_mon = val & 8'h3F;
            if (mask[2]) m_clk = val;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1: reset state
        chk("R1 sys", sys_reg, 0);
        chk("R1 mon", mon_reg, 0);
        chk("R1 clk", clkcfg_reg, 0);
        chk("R1 codec_run", codec_run, 0);
        chk("R1 phantom_on", phantom_on, 1);
        chk("R1 ext_sync", ext_sync, 0);
        chk("R1 rate", rate_x100hz, 441);

        // R2: separate registers
        bus_write(3'b001, 8'h8C, 1'b1); check_all("sys write");
        bus_write(3'b010, 8'hFF, 1'b1); check_all("mon write R4");
        bus_write(3'b100, 8'hE1, 1'b1); check_all("clk write");

        // R3: strobe with enable high ignored
        bus_write(3'b111, 8'h5A, 1'b0); check_all("R3 oe high");

        // R2: all strobes together
        bus_write(3'b111, 8'h37, 1'b1); check_all("R2 simultaneous");

        // R7: every internal rate code, bit4 set on odd codes
        for (int r = 0; r < 8; r++) begin
            bus_write(3'b100, {3'b010, r[0], 1'b0, r[2:0]}, 1'b1);
            check_all("R7 internal");
        end

        // R8: every external combination
        for (int c = 0; c < 16; c++) begin
            bus_write(3'b100, {3'b000, c[3], 1'b1, c[2:0]}, 1'b1);
            check_all("R8 external");
        end

        // R6: every input 1/2 code
        for (int m = 0; m < 4; m++) begin
            bus_write(3'b001, {2'b10, m[1:0], 4'b0101}, 1'b1);
            check_all("R6 in12");
        end

        // R10: capture latency
        @(negedge clk);
        bus_data = 8'hA5;
        repeat (3) @(negedge clk);
        bus_oe_n = 1'b0;
        repeat (3) @(negedge clk);
        sys_stb_n = 1'b0;
        repeat (3) @(negedge clk);
        sys_stb_n = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #1 chk("R10 before third edge", sys_reg, m_sys);
        @(posedge clk);
        #1 chk("R10 after third edge", sys_reg, 8'hA5);
        m_sys = 8'hA5;
        repeat (3) @(negedge clk);
        bus_oe_n = 1'b1;
        repeat (3) @(negedge clk);
        check_all("R10 settle");

        // Random writes: R2 R3 R5 R9
        for (int i = 0; i < 80; i++) begin
            bus_write(3'($urandom_range(1, 7)), 8'($urandom), $urandom_range(0, 9) != 0);
            check_all("random");
        end

        // R1: reset again after activity
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_sys = 8'h00; m_mon = 8'h00; m_clk = 8'h00;
        @(negedge clk);
        check_all("R1 re-reset");

        finish_run();
    end
endmodule